// File: doc/BRIEF.md
# Host Bus Command and Data Port

This block is the microcontroller-facing side of a USB device controller. An 8-bit host bus with an active-low chip select, read strobe and write strobe reaches it. One address bit sorts each access. When the bit is 1, a write carries a command byte. When the bit is 0, the access moves a data byte that belongs to the most recent command. Two variants exist. In the direct variant the bit comes from a dedicated address pin. In the multiplexed variant the bit is taken from data line 0 while the address latch enable is high, and the address pin is ignored.

The port keeps three commands:
- Set mode (F3h) takes a configuration byte and then a clock-division byte. One configuration bit drives the D+ pull-up enable.
- Set DMA (FBh) loads and reads back the DMA configuration byte.
- Chip ID (FDh) returns the 16-bit identifier over two data reads.

A fourth command, F4h, reads the interrupt register and clears it. While any bit of that register is set, the active-low interrupt output is held low as a level.

The port also watches the external reset pin together with chip select and raises a sticky flag on the orderings that would put the device into test mode. The external reset pin returns every register to its reset value. All bus inputs are sampled by the system clock, and a strobe acts on its falling edge.

Top module: `host_port_ctrl`

## Requirements
- R1: After the core reset, `int_n` is 1, `soft_conn` is 0, `clk_div` is 0Bh, `mode_cfg`, `dma_cfg` and `dout` are 00h, and `test_mode` is 0.
- R2: A write with address bit 1 stores a command and changes no configuration register. A write with address bit 0 is data for the current command. A data write before any command has no effect.
- R3: When MUX_ADDR=1, the address bit is the value on `din[0]` in the last cycle `ale` was high, and `a0` has no effect.
- R4: After command F3h, the first data write loads `mode_cfg` and the second loads `clk_div`. Later data writes change neither register until a new command arrives.
- R5: `soft_conn` equals bit SOFTCONN_BIT (default 4) of `mode_cfg`: 1 connects the pull-up and 0 releases it.
- R6: After command FBh, a data write loads `dma_cfg` and a data read returns it.
- R7: After command FDh, successive data reads return 12h, 10h, 12h, … (the ID 1012h, low byte first, alternating).
- R8: A 1 on `irq_src` sets that bit of the interrupt register. `int_n` is 0 on every cycle the register is nonzero, and command writes do not clear it.
- R9: After command F4h, a data read returns the interrupt register and clears it. A source bit that is set in the same cycle as the read is kept and appears on the next read.
- R10: `test_mode` becomes 1 when `cs_n` changes while `ext_rst_n` is held low, or when `ext_rst_n` changes while `cs_n` is held low. It stays 1 until the core reset.
- R11: While `ext_rst_n` is 0, every register returns to its R1 value, the current command is forgotten, and bus accesses are ignored.
- R12: A data read under an unknown command returns 00h, and a data write under an unknown command changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Core reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, watched for test-mode orderings |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Address bit (direct variant only) |
| ale | input | 1 | Address latch enable (multiplexed variant only) |
| din | input | DW | Bus data into the port |
| dout | output | DW | Read data, held until the next read |
| irq_src | input | INT_W | Interrupt set pulses |
| int_n | output | 1 | Level interrupt, active low |
| soft_conn | output | 1 | D+ pull-up enable |
| mode_cfg | output | DW | Configuration byte |
| clk_div | output | DW | Clock-division byte |
| dma_cfg | output | DW | DMA configuration byte |
| test_mode | output | 1 | Sticky illegal-ordering flag |

## Verification
A strobe that falls before a clock edge is decoded at that edge. The resulting register update, read byte or interrupt-register change is visible one clock edge after the strobe falls, and the interrupt output follows the register with no extra stage. The bench drives inputs on falling clock edges. It samples one falling edge after the strobe, so one rising edge has passed. Read bytes go through a queue of expected values that a monitor pops at exactly that point. The test-mode flag is registered behind one-cycle copies of chip select and the reset pin, so the bench waits two edges before it checks the flag.

// File: rtl/host_port_pkg.sv
`timescale 1ns/1ps
package host_port_pkg;
   localparam logic [7:0] OP_NONE     = 8'h00;
   localparam logic [7:0] OP_SET_MODE = 8'hF3;
   localparam logic [7:0] OP_IRQ_READ = 8'hF4;
   localparam logic [7:0] OP_SET_DMA  = 8'hFB;
   localparam logic [7:0] OP_CHIP_ID  = 8'hFD;

   // position within a command's data phase
   typedef enum logic [1:0] {
      SLOT_FIRST  = 2'd0,
      SLOT_SECOND = 2'd1,
      SLOT_DONE   = 2'd2
   } slot_t;
endpackage

// File: rtl/hp_bus_decode.sv
`timescale 1ns/1ps
module hp_bus_decode #(
   parameter bit MUX_ADDR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_rst_n,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic a0,
   input  logic ale,
   input  logic ale_bit,
   output logic cmd_wr_o,
   output logic dat_wr_o,
   output logic dat_rd_o
);
   logic rd_q, wr_q;
   logic addr_bit;
   logic wr_edge, rd_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b1;
         wr_q <= 1'b1;
      end else begin
         rd_q <= rd_n;
         wr_q <= wr_n;
      end
   end

   generate
      if (MUX_ADDR) begin : g_mux
         logic addr_q;
         logic unused_pin;
         assign unused_pin = a0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   addr_q <= 1'b0;
            else if (ale) addr_q <= ale_bit;
         end
         assign addr_bit = addr_q;

         assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ale |=> $stable(addr_q));
      end else begin : g_direct
         logic unused_mux;
         assign unused_mux = ale ^ ale_bit;
         assign addr_bit   = a0;
      end
   endgenerate

   assign wr_edge  = ext_rst_n && !cs_n && !wr_n && wr_q;
   assign rd_edge  = ext_rst_n && !cs_n && !rd_n && rd_q;
   assign cmd_wr_o = wr_edge && addr_bit;
   assign dat_wr_o = wr_edge && !addr_bit;
   assign dat_rd_o = rd_edge && !addr_bit;

   assert_ignore_in_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rst_n |-> !(cmd_wr_o || dat_wr_o || dat_rd_o));
endmodule

// File: rtl/hp_irq.sv
`timescale 1ns/1ps
module hp_irq #(
   parameter int INT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic [INT_W-1:0] set_i,
   input  logic             clr_i,
   output logic [INT_W-1:0] val_o,
   output logic             int_n_o
);
   logic [INT_W-1:0] pend_q;
   logic [INT_W-1:0] kept;

   // a read clears everything it returned; fresh sets survive
   assign kept = clr_i ? '0 : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= '0;
      else if (!ext_rst_n) pend_q <= '0;
      else                 pend_q <= kept | set_i;
   end

   assign val_o   = pend_q;
   assign int_n_o = (pend_q == '0);

   assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n_o && !clr_i && ext_rst_n) |=> !int_n_o);
   assert_irq_keep_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (set_i != '0) && ext_rst_n) |=> !int_n_o);
endmodule

// File: rtl/hp_testmode_det.sv
`timescale 1ns/1ps
module hp_testmode_det (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_rst_n,
   input  logic cs_n,
   output logic flag_o
);
   logic cs_q, er_q;
   logic cs_hit, er_hit;

   assign cs_hit = !ext_rst_n && !er_q && (cs_n != cs_q);
   assign er_hit = !cs_n && !cs_q && (ext_rst_n != er_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         er_q   <= 1'b1;
         flag_o <= 1'b0;
      end else begin
         cs_q <= cs_n;
         er_q <= ext_rst_n;
         if (cs_hit || er_hit) flag_o <= 1'b1;
      end
   end

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_o |=> flag_o);
endmodule

// File: rtl/hp_cmd_regs.sv
`timescale 1ns/1ps
module hp_cmd_regs
   import host_port_pkg::*;
#(
   parameter int          DW           = 8,
   parameter int          INT_W        = 8,
   parameter logic [15:0] CHIP_ID      = 16'h1012,
   parameter logic [7:0]  CLKDIV_RST   = 8'h0B,
   parameter int          SOFTCONN_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic             cmd_wr,
   input  logic             dat_wr,
   input  logic             dat_rd,
   input  logic [DW-1:0]    wdata,
   input  logic [INT_W-1:0] irq_val,
   output logic [DW-1:0]    rdata,
   output logic [DW-1:0]    cfg_o,
   output logic [DW-1:0]    clkdiv_o,
   output logic [DW-1:0]    dma_o,
   output logic             irq_clr
);
   localparam logic [DW-1:0] ID_LO  = CHIP_ID[7:0];
   localparam logic [DW-1:0] ID_HI  = CHIP_ID[15:8];
   localparam int            PAD_W  = DW - INT_W;

   generate
      if (DW != 8) begin : g_bad_dw
         $error("hp_cmd_regs: DW must be 8");
      end
      if (INT_W < 1 || INT_W > DW) begin : g_bad_int
         $error("hp_cmd_regs: INT_W must be 1..DW");
      end
      if (SOFTCONN_BIT < 0 || SOFTCONN_BIT >= DW) begin : g_bad_sc
         $error("hp_cmd_regs: SOFTCONN_BIT out of range");
      end
   endgenerate

   logic [7:0]    op_q;
   slot_t         slot_q;
   logic [DW-1:0] irq_word;

   generate
      if (PAD_W > 0) begin : g_pad
         assign irq_word = {{PAD_W{1'b0}}, irq_val};
      end else begin : g_nopad
         assign irq_word = irq_val;
      end
   endgenerate

   assign irq_clr = dat_rd && (op_q == OP_IRQ_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q     <= OP_NONE;
         slot_q   <= SLOT_FIRST;
         cfg_o    <= '0;
         clkdiv_o <= CLKDIV_RST;
         dma_o    <= '0;
         rdata    <= '0;
      end else if (!ext_rst_n) begin
         op_q     <= OP_NONE;
         slot_q   <= SLOT_FIRST;
         cfg_o    <= '0;
         clkdiv_o <= CLKDIV_RST;
         dma_o    <= '0;
         rdata    <= '0;
      end else if (cmd_wr) begin
         op_q   <= wdata;
         slot_q <= SLOT_FIRST;
      end else if (dat_wr) begin
         unique case (op_q)
            OP_SET_MODE: begin
               if (slot_q == SLOT_FIRST) begin
                  cfg_o  <= wdata;
                  slot_q <= SLOT_SECOND;
               end else if (slot_q == SLOT_SECOND) begin
                  clkdiv_o <= wdata;
                  slot_q   <= SLOT_DONE;
               end
            end
            OP_SET_DMA: dma_o <= wdata;
            default: ;
         endcase
      end else if (dat_rd) begin
         unique case (op_q)
            OP_SET_DMA:  rdata <= dma_o;
            OP_IRQ_READ: rdata <= irq_word;
            OP_CHIP_ID: begin
               rdata  <= (slot_q == SLOT_FIRST) ? ID_LO : ID_HI;
               slot_q <= (slot_q == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
            end
            default: rdata <= '0;
         endcase
      end
   end

   assert_cmd_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && ext_rst_n) |=> (slot_q == SLOT_FIRST));
   assert_clkdiv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && op_q == OP_SET_MODE && slot_q == SLOT_DONE && ext_rst_n) |=> $stable(clkdiv_o));
   assert_dma_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && op_q == OP_SET_DMA && ext_rst_n) |=> (dma_o == $past(wdata)));
endmodule

// File: rtl/host_port_ctrl.sv
`timescale 1ns/1ps
module host_port_ctrl #(
   parameter int          DW           = 8,
   parameter int          INT_W        = 8,
   parameter bit          MUX_ADDR     = 1'b0,
   parameter logic [15:0] CHIP_ID      = 16'h1012,
   parameter logic [7:0]  CLKDIV_RST   = 8'h0B,
   parameter int          SOFTCONN_BIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_rst_n,
   input  logic             cs_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             a0,
   input  logic             ale,
   input  logic [DW-1:0]    din,
   output logic [DW-1:0]    dout,
   input  logic [INT_W-1:0] irq_src,
   output logic             int_n,
   output logic             soft_conn,
   output logic [DW-1:0]    mode_cfg,
   output logic [DW-1:0]    clk_div,
   output logic [DW-1:0]    dma_cfg,
   output logic             test_mode
);
   logic             cmd_wr, dat_wr, dat_rd;
   logic             irq_clr;
   logic [INT_W-1:0] irq_val;

   hp_bus_decode #(.MUX_ADDR(MUX_ADDR)) u_dec (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .a0(a0),
      .ale(ale), .ale_bit(din[0]),
      .cmd_wr_o(cmd_wr), .dat_wr_o(dat_wr), .dat_rd_o(dat_rd)
   );

   hp_cmd_regs #(
      .DW(DW), .INT_W(INT_W), .CHIP_ID(CHIP_ID),
      .CLKDIV_RST(CLKDIV_RST), .SOFTCONN_BIT(SOFTCONN_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
      .cmd_wr(cmd_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
      .wdata(din), .irq_val(irq_val),
      .rdata(dout), .cfg_o(mode_cfg), .clkdiv_o(clk_div),
      .dma_o(dma_cfg), .irq_clr(irq_clr)
   );

   hp_irq #(.INT_W(INT_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
      .set_i(irq_src), .clr_i(irq_clr),
      .val_o(irq_val), .int_n_o(int_n)
   );

   hp_testmode_det u_tm (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
      .cs_n(cs_n), .flag_o(test_mode)
   );

   assign soft_conn = mode_cfg[SOFTCONN_BIT];

   assert_softconn_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(mode_cfg) |-> (soft_conn == mode_cfg[SOFTCONN_BIT]));
endmodule

// File: tb/host_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module host_port_ctrl_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n = 1'b0, ext_rst_n = 1'b1;
   logic       cs_n = 1'b1, cs_m_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic       a0 = 1'b0, ale = 1'b0;
   logic [7:0] din = 8'h00, irq_src = 8'h00;
   logic [7:0] dout, mode_cfg, clk_div, dma_cfg;
   logic       int_n, soft_conn, test_mode;
   logic [7:0] m_dout, m_cfg, m_div, m_dma;
   logic       m_int_n, m_sc, m_tm;

   int   checks = 0, errors = 0;
   bit   done = 1'b0;
   logic smp = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   host_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .cs_n(cs_n),
      .rd_n(rd_n), .wr_n(wr_n), .a0(a0), .ale(ale), .din(din), .dout(dout),
      .irq_src(irq_src), .int_n(int_n), .soft_conn(soft_conn),
      .mode_cfg(mode_cfg), .clk_div(clk_div), .dma_cfg(dma_cfg),
      .test_mode(test_mode)
   );

   host_port_ctrl #(.MUX_ADDR(1'b1)) dut_mux_i (
      .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n), .cs_n(cs_m_n),
      .rd_n(rd_n), .wr_n(wr_n), .a0(a0), .ale(ale), .din(din), .dout(m_dout),
      .irq_src(8'h00), .int_n(m_int_n), .soft_conn(m_sc),
      .mode_cfg(m_cfg), .clk_div(m_div), .dma_cfg(m_dma), .test_mode(m_tm)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_wr(input logic ab, input logic [7:0] d);
      @(negedge clk); a0 = ab; din = d; cs_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
   endtask

   task automatic bus_rd(input logic [7:0] e, input string r, input logic [7:0] src);
      exp_q.push_back(e); tag_q.push_back(r);
      @(negedge clk); a0 = 1'b0; cs_n = 1'b0; rd_n = 1'b0; irq_src = src;
      @(negedge clk); rd_n = 1'b1; cs_n = 1'b1; irq_src = 8'h00; smp = 1'b1;
      @(negedge clk); smp = 1'b0;
   endtask

   task automatic mux_wr(input logic ab, input logic [7:0] d);
      @(negedge clk); ale = 1'b1; din = {7'b0, ab}; a0 = ~ab;
      @(negedge clk); ale = 1'b0; din = d; cs_m_n = 1'b0; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1; cs_m_n = 1'b1;
   endtask

   // scoreboard monitor: read data due one rising edge after the strobe falls
   initial begin
      forever begin
         logic [7:0] e;
         string      t;
         @(negedge clk); #1;
         if (smp) begin
            if (exp_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL scoreboard: actual %h expected none", dout);
            end else begin
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(t, {8'h00, dout}, {8'h00, e});
            end
         end
      end
   end

   initial begin
      tick(3); rst_n = 1'b1; tick(1);
      chk("R1 int_n", int_n, 1); chk("R1 soft_conn", soft_conn, 0);
      chk("R1 clk_div", clk_div, 16'h0B); chk("R1 dma", dma_cfg, 0);
      chk("R1 cfg", mode_cfg, 0); chk("R1 test", test_mode, 0); chk("R1 dout", dout, 0);

      bus_wr(1'b0, 8'h55); tick(1);
      chk("R2 data before cmd", mode_cfg, 0);
      bus_wr(1'b1, 8'hF3); tick(1);
      chk("R2 cmd not data", clk_div, 16'h0B);
      bus_wr(1'b0, 8'h10); tick(1);
      chk("R4 cfg byte", mode_cfg, 16'h10); chk("R5 soft_conn on", soft_conn, 1);
      bus_wr(1'b0, 8'h03); tick(1);
      chk("R4 div byte", clk_div, 16'h03);
      bus_wr(1'b0, 8'h07); tick(1);
      chk("R4 extra ignored div", clk_div, 16'h03); chk("R4 extra ignored cfg", mode_cfg, 16'h10);
      bus_wr(1'b1, 8'hF3); bus_wr(1'b0, 8'hEF); tick(1);
      chk("R5 soft_conn off", soft_conn, 0); chk("R4 cfg reload", mode_cfg, 16'hEF);

      bus_wr(1'b1, 8'hFB); bus_wr(1'b0, 8'h05); tick(1);
      chk("R6 dma write", dma_cfg, 16'h05);
      bus_rd(8'h05, "R6 dma read", 8'h00);

      bus_wr(1'b1, 8'hFD);
      bus_rd(8'h12, "R7 id low", 8'h00);
      bus_rd(8'h10, "R7 id high", 8'h00);
      bus_rd(8'h12, "R7 id wrap", 8'h00);

      bus_wr(1'b1, 8'h42);
      bus_rd(8'h00, "R12 unknown read", 8'h00);
      bus_wr(1'b0, 8'h99); tick(1);
      chk("R12 unknown write", dma_cfg, 16'h05);

      @(negedge clk); irq_src = 8'h05;
      @(negedge clk); irq_src = 8'h00;
      tick(1); chk("R8 int asserted", int_n, 0);
      tick(5); chk("R8 int level", int_n, 0);
      bus_wr(1'b1, 8'hF4); tick(1);
      chk("R8 cmd keeps int", int_n, 0);
      bus_rd(8'h05, "R9 irq read", 8'h00);
      chk("R9 cleared", int_n, 1);
      @(negedge clk); irq_src = 8'h02;
      @(negedge clk); irq_src = 8'h00;
      bus_rd(8'h02, "R9 read with new set", 8'h80);
      chk("R9 new set kept", int_n, 0);
      bus_rd(8'h80, "R9 second read", 8'h00);
      chk("R9 cleared again", int_n, 1);

      mux_wr(1'b1, 8'hFB); mux_wr(1'b0, 8'h3C); tick(1);
      chk("R3 mux dma", m_dma, 16'h3C);
      chk("R3 other port idle", dma_cfg, 16'h05);
      mux_wr(1'b1, 8'h42); mux_wr(1'b0, 8'h11); tick(1);
      chk("R3 a0 ignored", m_dma, 16'h3C);

      bus_wr(1'b1, 8'hF3); bus_wr(1'b0, 8'h10);
      @(negedge clk); irq_src = 8'h01;
      @(negedge clk); irq_src = 8'h00;
      tick(1);
      chk("R5 soft_conn pre", soft_conn, 1); chk("R8 int pre", int_n, 0);
      @(negedge clk); ext_rst_n = 1'b0;
      tick(2);
      chk("R11 soft_conn", soft_conn, 0); chk("R11 clk_div", clk_div, 16'h0B);
      chk("R11 dma", dma_cfg, 0); chk("R11 int", int_n, 1); chk("R11 cfg", mode_cfg, 0);
      chk("R10 no flag yet", test_mode, 0);
      bus_wr(1'b1, 8'hFB); bus_wr(1'b0, 8'hAA); tick(2);
      chk("R11 ignored", dma_cfg, 0);
      chk("R10 cs toggle in reset", test_mode, 1);
      @(negedge clk); ext_rst_n = 1'b1;
      tick(2);
      chk("R10 sticky", test_mode, 1);
      bus_wr(1'b0, 8'hAA); tick(1);
      chk("R11 cmd forgotten", dma_cfg, 0);
      @(negedge clk); rst_n = 1'b0;
      tick(2); rst_n = 1'b1; tick(2);
      chk("R10 cleared by core reset", test_mode, 0);
      @(negedge clk); cs_n = 1'b0;
      tick(2); ext_rst_n = 1'b0;
      tick(2); ext_rst_n = 1'b1;
      tick(1); cs_n = 1'b1;
      tick(2);
      chk("R10 reset toggle under cs", test_mode, 1);

      tick(2);
      chk("scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule